// File: doc/BRIEF.md
# Up/down wiper position controller

This block is the digital control section of a 100-position resistor ladder. A host moves the wiper with three slow control lines. An active-low select line enables the part. Each falling edge of an increment strobe moves the wiper by one tap, and a direction line chooses up or down. The block holds the wiper position in a 7-bit register and drives a one-hot bus that closes exactly one of the hundred tap switches. The position stops at both ends of the ladder; it does not wrap.

A nonvolatile copy of the position is modelled as a register with its own power-on reset. When select is released while the strobe is high, the current position is written into that copy. The cell then reports busy for a fixed number of clock cycles. A new selection that starts while the cell is busy is ignored. After the logic reset is released, the position is reloaded from the saved copy. If nothing has been saved since power-on, the position starts at mid-scale.

The three control inputs are asynchronous. Each one passes through a two-flop synchroniser, and all timing is counted in system clock cycles.

Top module: `tapctl_top`

## Requirements
- R1: After power-on reset (`por_n` and `rst_n` low, then released), `pos_o` is 50, `tap_o` has only bit 50 set, and `busy_o` is 0.
- R2: `tap_o` always has exactly one bit set, and that bit is at index `pos_o`.
- R3: While selected, each high-to-low transition of `inc_i` moves `pos_o` by one. It moves up when `up_i` is 1 and down when `up_i` is 0. A low-to-high transition of `inc_i` does not move the wiper.
- R4: A step up at position 99, or a step down at position 0, leaves the position unchanged.
- R5: While `sel_n_i` is high, strobes on `inc_i` leave `pos_o` unchanged.
- R6: When `sel_n_i` rises while the block is selected and `inc_i` is high, the position is saved. `busy_o` rises 3 clock edges after `sel_n_i` rises and stays high for exactly `STORE_CYCLES` cycles.
- R7: When `sel_n_i` rises while `inc_i` is low, nothing is saved and `busy_o` stays 0.
- R8: A falling edge of `sel_n_i` that arrives while `busy_o` is high does not select the block. Strobes have no effect until `sel_n_i` goes high and then low again after busy has cleared.
- R9: One clock edge after `rst_n` is released, `pos_o` holds the saved value. Only `por_n` clears the saved value.
- R10: `pos_o` changes on the third rising clock edge after `inc_i` falls, and not on an earlier edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears the nonvolatile copy and its busy timer |
| rst_n | input | 1 | Logic reset, active low; the nonvolatile copy survives it |
| sel_n_i | input | 1 | Select, active low, asynchronous |
| inc_i | input | 1 | Increment strobe, asynchronous; the wiper moves on its falling edge |
| up_i | input | 1 | Direction: 1 up, 0 down |
| pos_o | output | 7 | Current wiper position, 0 to 99 |
| tap_o | output | 100 | One-hot tap select |
| busy_o | output | 1 | Nonvolatile write in progress |

## Verification
Every input passes through two synchroniser flops and one registered edge detector. A wiper step or the start of a save therefore becomes visible on the third rising edge after the input changes. `tap_o` follows `pos_o` in the same cycle, and the reload after reset appears one edge after `rst_n` is released. The bench drives inputs on falling clock edges and samples on falling edges. It measures the step latency and the busy window edge by edge: it checks that nothing has changed after two edges, that the change is present after three, and that busy is still high after `STORE_CYCLES + 2` edges and low one edge later. Everywhere else it waits at least four cycles after each stimulus before it samples.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

    // Synchronised view of the three control lines
    typedef struct packed {
        logic sel;   // select, active low
        logic inc;   // increment strobe
        logic up;    // direction
    } pins_t;

    // Idle levels while in reset: deselected, strobe high, direction down
    localparam logic [2:0] PINS_IDLE = 3'b110;

endpackage

// File: rtl/tapctl_sync2.sv
module tapctl_sync2 #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] meta_d;
    logic [W-1:0] sync_q;
    logic [W-1:0] sync_d;

    always_comb begin
        meta_d = d_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/tapctl_decode.sv
module tapctl_decode #(
    parameter int NUM_TAPS = 100,
    parameter int POS_W    = $clog2(NUM_TAPS)
) (
    input  logic [POS_W-1:0]    pos_i,
    output logic [NUM_TAPS-1:0] tap_o
);
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_o[g] = (pos_i == POS_W'(g));
    end
endmodule

// File: rtl/tapctl_nvcell.sv
module tapctl_nvcell #(
    parameter int POS_W        = 7,
    parameter int STORE_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en_i,
    input  logic [POS_W-1:0] wr_data_i,
    output logic [POS_W-1:0] rd_data_o,
    output logic             rd_valid_o,
    output logic             busy_o
);
    localparam int CNT_W = $clog2(STORE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES);

    typedef struct packed {
        logic [POS_W-1:0] data;
        logic             valid;
        logic [CNT_W-1:0] cnt;
    } nv_t;

    nv_t nv_q;
    nv_t nv_d;

    always_comb begin
        nv_d = nv_q;
        if (nv_q.cnt != '0) begin
            nv_d.cnt = nv_q.cnt - 1'b1;
        end else if (wr_en_i) begin
            nv_d.data  = wr_data_i;
            nv_d.valid = 1'b1;
            nv_d.cnt   = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            nv_q <= '0;
        end else begin
            nv_q <= nv_d;
        end
    end

    assign rd_data_o  = nv_q.data;
    assign rd_valid_o = nv_q.valid;
    assign busy_o     = (nv_q.cnt != '0);
endmodule

// File: rtl/tapctl_top.sv
module tapctl_top
    import tapctl_pkg::*;
#(
    parameter int NUM_TAPS     = 100,
    parameter int DEFAULT_POS  = 50,
    parameter int STORE_CYCLES = 1000,
    localparam int POS_W       = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_n,
    input  logic                sel_n_i,
    input  logic                inc_i,
    input  logic                up_i,
    output logic [POS_W-1:0]    pos_o,
    output logic [NUM_TAPS-1:0] tap_o,
    output logic                busy_o
);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(NUM_TAPS - 1);
    localparam logic [POS_W-1:0] POS_DEF = POS_W'(DEFAULT_POS);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             active;
        logic             sel_prev;
        logic             inc_prev;
        logic             loaded;
    } st_t;

    pins_t pin_raw;
    pins_t pin_s;
    st_t   st_q;
    st_t   st_d;

    logic             store_en;
    logic [POS_W-1:0] nv_data;
    logic             nv_valid;
    logic             nv_busy;
    logic             sel_rise;
    logic             sel_fall;
    logic             inc_fall;

    // Exposed for the bound checker
    logic             sel_active;
    logic             pos_loaded;

    assign pin_raw = '{sel: sel_n_i, inc: inc_i, up: up_i};

    tapctl_sync2 #(
        .W       (3),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    always_comb begin
        st_d     = st_q;
        store_en = 1'b0;
        sel_rise = pin_s.sel & ~st_q.sel_prev;
        sel_fall = ~pin_s.sel & st_q.sel_prev;
        inc_fall = ~pin_s.inc & st_q.inc_prev;

        st_d.sel_prev = pin_s.sel;
        st_d.inc_prev = pin_s.inc;

        if (!st_q.loaded) begin
            st_d.pos    = nv_valid ? nv_data : POS_DEF;
            st_d.loaded = 1'b1;
        end else if (st_q.active) begin
            if (inc_fall) begin
                if (pin_s.up) begin
                    st_d.pos = (st_q.pos == POS_MAX) ? st_q.pos : st_q.pos + 1'b1;
                end else begin
                    st_d.pos = (st_q.pos == '0) ? st_q.pos : st_q.pos - 1'b1;
                end
            end
            if (sel_rise) begin
                st_d.active = 1'b0;
                store_en    = pin_s.inc;
            end
        end else if (sel_fall && !nv_busy) begin
            st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pos: POS_DEF, active: 1'b0, sel_prev: 1'b1,
                      inc_prev: 1'b1, loaded: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    tapctl_nvcell #(
        .POS_W        (POS_W),
        .STORE_CYCLES (STORE_CYCLES)
    ) u_nv (
        .clk        (clk),
        .por_n      (por_n),
        .wr_en_i    (store_en),
        .wr_data_i  (st_q.pos),
        .rd_data_o  (nv_data),
        .rd_valid_o (nv_valid),
        .busy_o     (nv_busy)
    );

    tapctl_decode #(
        .NUM_TAPS (NUM_TAPS),
        .POS_W    (POS_W)
    ) u_dec (
        .pos_i (st_q.pos),
        .tap_o (tap_o)
    );

    assign pos_o      = st_q.pos;
    assign busy_o     = nv_busy;
    assign sel_active = st_q.active;
    assign pos_loaded = st_q.loaded;
endmodule

// File: rtl/tapctl_checker.sv
module tapctl_checker #(
    parameter int NUM_TAPS = 100,
    parameter int POS_W    = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                por_n,
    input logic [POS_W-1:0]    pos,
    input logic [NUM_TAPS-1:0] tap,
    input logic                busy,
    input logic                active,
    input logic                loaded
);
    // R2: exactly one tap, at the wiper position
    assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap) == 1) && tap[pos]);

    // R4: position never leaves the ladder
    assert_pos_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |-> (int'(pos) <= NUM_TAPS - 1));

    // R3: after the reload the wiper moves by at most one tap per cycle
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && $past(loaded)) |->
            (pos == $past(pos)) || (pos == $past(pos) + 1'b1) || ($past(pos) == pos + 1'b1));

    // R5: no movement while not selected
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !active) |=> $stable(pos));

    // R8: a selection cannot begin while the store is busy
    assert_busy_blocks_select_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (busy && !active) |=> !active);
endmodule

bind tapctl_top tapctl_checker #(
    .NUM_TAPS (NUM_TAPS),
    .POS_W    (POS_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .por_n  (por_n),
    .pos    (pos_o),
    .tap    (tap_o),
    .busy   (busy_o),
    .active (sel_active),
    .loaded (pos_loaded)
);

// File: tb/tapctl_top_tb.sv
`timescale 1ns/1ps
module tapctl_top_tb;
    localparam int NT    = 100;
    localparam int PW    = 7;
    localparam int STORE = 40;

    localparam logic [2:0] A_SEL  = 3'd0;  // select
    localparam logic [2:0] A_PUL  = 3'd1;  // strobe while selected
    localparam logic [2:0] A_PDES = 3'd2;  // strobe low, then deselect (no store)
    localparam logic [2:0] A_DPUL = 3'd3;  // strobe while deselected
    localparam logic [2:0] A_DSTO = 3'd4;  // deselect with strobe high (store)

    // {action, up, expected position}
    localparam logic [11:0] VECS [0:13] = '{
        {A_SEL,  1'b1, 8'd50},
        {A_PUL,  1'b1, 8'd51},
        {A_PUL,  1'b1, 8'd52},
        {A_PUL,  1'b0, 8'd51},
        {A_PDES, 1'b0, 8'd50},
        {A_DPUL, 1'b1, 8'd50},
        {A_DPUL, 1'b0, 8'd50},
        {A_SEL,  1'b0, 8'd50},
        {A_PUL,  1'b0, 8'd49},
        {A_PUL,  1'b0, 8'd48},
        {A_DSTO, 1'b1, 8'd48},
        {A_SEL,  1'b1, 8'd48},
        {A_PUL,  1'b1, 8'd49},
        {A_PDES, 1'b1, 8'd50}
    };

    logic          clk = 1'b0;
    logic          por_n, rst_n, sel_n, inc, up;
    logic [PW-1:0] pos;
    logic [NT-1:0] tap;
    logic          busy;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    tapctl_top #(
        .NUM_TAPS     (NT),
        .DEFAULT_POS  (50),
        .STORE_CYCLES (STORE)
    ) u_dut (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .sel_n_i (sel_n),
        .inc_i   (inc),
        .up_i    (up),
        .pos_o   (pos),
        .tap_o   (tap),
        .busy_o  (busy)
    );

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_pos(input string req, input int exp);
        logic [NT-1:0] e;
        chk(req, int'(pos), exp);
        e = '0;
        e[exp] = 1'b1;
        checks++;
        if (tap !== e) begin
            errors++;
            $display("FAIL %s tap actual %h expected %h", req, tap, e);
        end
    endtask

    task automatic pulse();
        inc = 1'b0; w(4);
        inc = 1'b1; w(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; sel_n = 1'b1; inc = 1'b1; up = 1'b0;
        w(5);
        por_n = 1'b1; rst_n = 1'b1;
        w(4);
        chk_pos("R1 reset position", 50);
        chk("R1 reset busy", int'(busy), 0);

        // Vector table
        for (int i = 0; i < 14; i++) begin
            logic [2:0] act;
            logic       u;
            int         exp;
            string      tag;
            act = VECS[i][11:9];
            u   = VECS[i][8];
            exp = int'(VECS[i][7:0]);
            up  = u;
            case (act)
                A_SEL:  begin sel_n = 1'b0; w(4); tag = "R2 select"; end
                A_PUL:  begin w(2); pulse(); tag = "R3 step"; end
                A_PDES: begin
                    w(2); inc = 1'b0; w(4); sel_n = 1'b1; w(4); inc = 1'b1; w(4);
                    tag = "R7 step and release";
                end
                A_DPUL: begin w(2); pulse(); tag = "R5 deselected strobe"; end
                default: begin sel_n = 1'b1; w(STORE + 10); tag = "R6 store"; end
            endcase
            chk_pos(tag, exp);
        end

        // R10: latency of a step
        sel_n = 1'b0; up = 1'b1; w(4);
        inc = 1'b0;
        w(2); chk("R10 no change after two edges", int'(pos), 50);
        w(1); chk("R10 change after three edges", int'(pos), 51);
        inc = 1'b1; w(4);
        // R3: rising strobe edge did not move the wiper
        chk("R3 rising strobe", int'(pos), 51);

        // R4: saturation at both ends
        for (int i = 0; i < 50; i++) pulse();
        chk_pos("R4 top", 99);
        for (int i = 0; i < 3; i++) pulse();
        chk_pos("R4 hold at top", 99);
        up = 1'b0; w(2);
        for (int i = 0; i < 102; i++) pulse();
        chk_pos("R4 bottom", 0);
        for (int i = 0; i < 3; i++) pulse();
        chk_pos("R4 hold at bottom", 0);

        // R6: store of 0 and busy window
        sel_n = 1'b1;
        w(2); chk("R6 busy not yet", int'(busy), 0);
        w(1); chk("R6 busy rises", int'(busy), 1);
        w(STORE - 1); chk("R6 busy last cycle", int'(busy), 1);
        w(1); chk("R6 busy clears", int'(busy), 0);

        // R8: selection during busy is ignored
        sel_n = 1'b0; up = 1'b1; w(4); pulse();
        chk_pos("R8 reselect after busy", 1);
        sel_n = 1'b1; w(10);
        chk("R8 second store busy", int'(busy), 1);
        sel_n = 1'b0; w(4); pulse();
        chk_pos("R8 strobe during busy", 1);
        w(STORE + 5);
        chk("R8 busy cleared", int'(busy), 0);
        pulse();
        chk_pos("R8 still not selected", 1);
        sel_n = 1'b1; w(4);
        chk("R8 release without selection no store", int'(busy), 0);
        sel_n = 1'b0; w(4); pulse();
        chk_pos("R8 fresh selection", 2);

        // R7: release with strobe low does not store
        w(2); inc = 1'b0; w(4); sel_n = 1'b1; w(4); inc = 1'b1; w(4);
        chk_pos("R7 moved on release", 3);
        chk("R7 no busy", int'(busy), 0);

        // R9: logic reset reloads the saved value (1), not the live one
        rst_n = 1'b0; w(3);
        rst_n = 1'b1; w(4);
        chk_pos("R9 reload saved", 1);

        // R9 and R1: power-on reset clears the saved copy
        por_n = 1'b0; rst_n = 1'b0; w(3);
        por_n = 1'b1; rst_n = 1'b1; w(4);
        chk_pos("R9 por default", 50);
        chk("R1 por busy", int'(busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule